// File: doc/BRIEF.md
# Segment Descriptor Cache and Checker

This block is the segmentation stage of a small processor. It keeps six segment registers. Each one holds a 16-bit selector that software can load and a hidden shadow copy of the segment's descriptor: a 32-bit byte base, a 24-bit limit, and permission and mode flags. When a selector is loaded in descriptor mode, the block fetches that segment's two-word descriptor from a table in memory through a single read port. It then writes the decoded fields into the shadow. Every load causes a new fetch, even when the selector value has not changed.

On the translation side, a request names a segment, a 32-bit offset and an access kind. One cycle after the request is accepted, the block returns either the linear address (shadow base plus offset) or a fault. A fault is raised for a forbidden access kind, for an offset outside the segment, or for a nonexistent segment number. Limits can scale by 4096 and segments can grow downward. In legacy mode there is no table fetch: a selector load directly sets the base to sixteen times the selector, the limit to 64 KiB and full permissions. While a segment's descriptor is being loaded, requests to that segment are held off and requests to the other segments go through.

Top module: `seg_xlate_unit`

## Requirements
- R1: After reset, `busy` and `mem_rd_req` are low, no result is valid, and every translation faults because all shadow permissions are clear.
- R2: A descriptor-mode selector write makes two one-cycle reads, at `dt_base + 8*sel[15:2]` and then 4 bytes higher. Selector bits [1:0] take no part in the address.
- R3: Writing the same selector value again makes two new reads. The shadow is never reused.
- R4: The first descriptor word is the base. In the second word, bits [23:0] are the limit, bit 24 permits read, bit 25 permits write, bit 26 permits execute, bit 27 marks expand-down and bit 28 marks 4 KiB granularity.
- R5: An accepted request gives `xl_valid` exactly one cycle later. A non-faulting result carries base plus offset modulo 2^32.
- R6: Access kind 0 is read, 1 is write, 2 is execute and 3 is reserved. A kind whose permission bit is clear faults, kind 3 always faults, and a faulting result shows address 0.
- R7: In a normal segment, an offset up to and including the effective limit is valid, and a larger offset faults.
- R8: In an expand-down segment, an offset at or below the effective limit faults, and any larger offset up to 0xFFFFFFFF is valid.
- R9: With granularity set, the effective limit is `limit*4096 + 4095`.
- R10: In legacy mode, a selector write causes no memory read and raises no `busy`. The next request to that segment uses base `sel*16`, limit 0xFFFF and all three kinds.
- R11: A segment counts as busy from its selector write until its shadow is loaded. During that time `busy` is high and `xl_ready` is low for that segment only, while requests to other segments are accepted.
- R12: If a segment's selector is written again while its fetch is still running, the shadow ends up holding the descriptor of the last selector written.
- R13: Segment numbers 6 and 7 translate to a fault and are always ready. Selector writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| legacy_mode | input | 1 | 1: selectors form the base directly, with no fetch |
| dt_base | input | 32 | Byte address of descriptor table entry 0 |
| sel_wr_en | input | 1 | Selector load strobe |
| sel_wr_idx | input | 3 | Segment register to load |
| sel_wr_data | input | 16 | New selector value |
| mem_rd_req | output | 1 | One-cycle read request |
| mem_rd_addr | output | 32 | Byte address of the requested word |
| mem_rd_valid | input | 1 | Read data is present |
| mem_rd_data | input | 32 | Read data word |
| xl_req | input | 1 | Translation request |
| xl_seg | input | 3 | Segment number of the request |
| xl_off | input | 32 | Offset within the segment |
| xl_kind | input | 2 | Access kind (0 read, 1 write, 2 execute) |
| xl_ready | output | 1 | Request is accepted this cycle |
| xl_valid | output | 1 | Result is valid |
| xl_addr | output | 32 | Linear address (0 on fault) |
| xl_fault | output | 1 | Result is a fault |
| busy | output | 1 | A descriptor load is pending or running |

## Verification
The checker assumes two things about the memory. It returns each word at least one cycle after the request and only for a request that is outstanding. The checker also assumes that `legacy_mode` changes only while `busy` is low. The bench's memory model answers every read exactly two cycles after it is issued. The bench changes the mode only after waiting for `busy` to drop. Translation requests are held until `xl_ready` is sampled high, and the bench never loads a selector in the same cycle as a request to that same segment.

// File: rtl/segx_pkg.sv
package segx_pkg;

  localparam int BASE_W    = 32;
  localparam int LIM_W     = 24;
  localparam int GRAN_SH   = 12;
  localparam int EXT_W     = LIM_W + GRAN_SH;
  localparam int LEGACY_SH = 4;
  localparam logic [LIM_W-1:0] LEGACY_LIM = 24'h00FFFF;

  // flag positions inside the second descriptor word
  localparam int D_RD = 24;
  localparam int D_WR = 25;
  localparam int D_EX = 26;
  localparam int D_DN = 27;
  localparam int D_GR = 28;

  typedef enum logic [1:0] {
    ACC_RD  = 2'd0,
    ACC_WR  = 2'd1,
    ACC_EX  = 2'd2,
    ACC_RSV = 2'd3
  } acc_kind_e;

  typedef struct packed {
    logic [BASE_W-1:0] base;
    logic [LIM_W-1:0]  limit;
    logic              rd;
    logic              wr;
    logic              ex;
    logic              dn;
    logic              gr;
  } shadow_t;

  function automatic shadow_t legacy_shadow(input logic [BASE_W-1:0] sel_ext);
    shadow_t s;
    s.base  = sel_ext << LEGACY_SH;
    s.limit = LEGACY_LIM;
    s.rd    = 1'b1;
    s.wr    = 1'b1;
    s.ex    = 1'b1;
    s.dn    = 1'b0;
    s.gr    = 1'b0;
    return s;
  endfunction

  function automatic shadow_t decode_desc(input logic [31:0] w_lo, input logic [31:0] w_hi);
    shadow_t s;
    s.base  = w_lo;
    s.limit = w_hi[LIM_W-1:0];
    s.rd    = w_hi[D_RD];
    s.wr    = w_hi[D_WR];
    s.ex    = w_hi[D_EX];
    s.dn    = w_hi[D_DN];
    s.gr    = w_hi[D_GR];
    return s;
  endfunction

endpackage

// File: rtl/seg_shadow_file.sv
module seg_shadow_file
  import segx_pkg::*;
#(
  parameter int NSEG  = 6,
  parameter int IDX_W = 3,
  parameter int SEL_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             legacy_i,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [SEL_W-1:0] wr_sel_i,
  input  logic             commit_en_i,
  input  logic [IDX_W-1:0] commit_idx_i,
  input  shadow_t          commit_data_i,
  output logic [SEL_W-1:0] sel_o [NSEG],
  output shadow_t          shd_o [NSEG]
);

  logic [SEL_W-1:0] sel_q [NSEG];
  shadow_t          shd_q [NSEG];

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    logic hit_wr;
    logic hit_commit;
    assign hit_wr     = wr_en_i && (wr_idx_i == IDX_W'(g));
    assign hit_commit = commit_en_i && (commit_idx_i == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        sel_q[g] <= '0;
        shd_q[g] <= '0;
      end else begin
        if (hit_commit) begin
          shd_q[g] <= commit_data_i;
        end
        if (hit_wr) begin
          sel_q[g] <= wr_sel_i;
          if (legacy_i) begin
            shd_q[g] <= legacy_shadow(BASE_W'(wr_sel_i));
          end
        end
      end
    end

    assign sel_o[g] = sel_q[g];
    assign shd_o[g] = shd_q[g];
  end

endmodule

// File: rtl/seg_fetch_engine.sv
module seg_fetch_engine
  import segx_pkg::*;
#(
  parameter int NSEG   = 6,
  parameter int IDX_W  = 3,
  parameter int SEL_W  = 16,
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int PRIV_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             legacy_i,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [AW-1:0]    dt_base_i,
  input  logic [SEL_W-1:0] sel_i [NSEG],
  output logic             mem_rd_req_o,
  output logic [AW-1:0]    mem_rd_addr_o,
  input  logic             mem_rd_valid_i,
  input  logic [DW-1:0]    mem_rd_data_i,
  output logic             commit_en_o,
  output logic [IDX_W-1:0] commit_idx_o,
  output shadow_t          commit_data_o,
  output logic [NSEG-1:0]  seg_busy_o
);

  localparam int ENTRY_SH = 3;           // 8 bytes per descriptor
  localparam int WORD_B   = DW / 8;

  typedef enum logic [1:0] {F_IDLE, F_W0, F_W1} fstate_e;

  fstate_e          state_q;
  logic [NSEG-1:0]  pend_q, pend_d;
  logic [IDX_W-1:0] cur_q;
  logic             stale_q;
  logic [DW-1:0]    w0_q;
  logic             pick_vld;
  logic [IDX_W-1:0] pick_idx;
  logic             stale_set;

  // lowest pending segment wins
  always_comb begin
    pick_vld = 1'b0;
    pick_idx = '0;
    for (int i = NSEG - 1; i >= 0; i--) begin
      if (pend_q[i]) begin
        pick_vld = 1'b1;
        pick_idx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    pend_d = pend_q;
    if (state_q == F_IDLE && pick_vld) begin
      pend_d[pick_idx] = 1'b0;
    end
    if (wr_en_i) begin
      pend_d[wr_idx_i] = !legacy_i;
    end
  end

  // a rewrite of the segment being fetched makes the fetch result obsolete
  always_comb begin
    stale_set = 1'b0;
    if (wr_en_i) begin
      if (state_q != F_IDLE && wr_idx_i == cur_q) begin
        stale_set = 1'b1;
      end
      if (state_q == F_IDLE && pick_vld && wr_idx_i == pick_idx) begin
        stale_set = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= F_IDLE;
      pend_q        <= '0;
      cur_q         <= '0;
      stale_q       <= 1'b0;
      w0_q          <= '0;
      mem_rd_req_o  <= 1'b0;
      mem_rd_addr_o <= '0;
      commit_en_o   <= 1'b0;
      commit_idx_o  <= '0;
      commit_data_o <= '0;
    end else begin
      pend_q       <= pend_d;
      mem_rd_req_o <= 1'b0;
      commit_en_o  <= 1'b0;
      case (state_q)
        F_IDLE: begin
          stale_q <= stale_set;
          if (pick_vld) begin
            mem_rd_req_o  <= 1'b1;
            mem_rd_addr_o <= dt_base_i +
                             (AW'(sel_i[pick_idx] >> PRIV_W) << ENTRY_SH);
            cur_q         <= pick_idx;
            state_q       <= F_W0;
          end
        end
        F_W0: begin
          stale_q <= stale_q | stale_set;
          if (mem_rd_valid_i) begin
            w0_q          <= mem_rd_data_i;
            mem_rd_req_o  <= 1'b1;
            mem_rd_addr_o <= mem_rd_addr_o + AW'(WORD_B);
            state_q       <= F_W1;
          end
        end
        F_W1: begin
          stale_q <= stale_q | stale_set;
          if (mem_rd_valid_i) begin
            commit_en_o   <= !(stale_q | stale_set);
            commit_idx_o  <= cur_q;
            commit_data_o <= decode_desc(w0_q, mem_rd_data_i);
            state_q       <= F_IDLE;
          end
        end
        default: state_q <= F_IDLE;
      endcase
    end
  end

  always_comb begin
    for (int i = 0; i < NSEG; i++) begin
      seg_busy_o[i] = pend_q[i]
                    | (state_q != F_IDLE && cur_q == IDX_W'(i))
                    | (commit_en_o && commit_idx_o == IDX_W'(i));
    end
  end

endmodule

// File: rtl/seg_limit_check.sv
module seg_limit_check
  import segx_pkg::*;
#(
  parameter int NSEG  = 6,
  parameter int IDX_W = 3,
  parameter int AW    = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept_i,
  input  logic [IDX_W-1:0] seg_i,
  input  logic [AW-1:0]    off_i,
  input  logic [1:0]       kind_i,
  input  shadow_t          shd_i [NSEG],
  output logic             valid_o,
  output logic [AW-1:0]    addr_o,
  output logic             fault_o
);

  logic             seg_ok;
  logic [IDX_W-1:0] seg_safe;
  shadow_t          s;
  logic [EXT_W-1:0] eff_lim;
  logic [EXT_W-1:0] off_ext;
  logic             over;
  logic             lim_bad;
  logic             kind_bad;
  logic             fault_c;
  logic [AW-1:0]    lin;

  assign seg_ok   = (32'(seg_i) < NSEG);
  assign seg_safe = seg_ok ? seg_i : '0;
  assign s        = shd_i[seg_safe];

  assign eff_lim = s.gr ? {s.limit, {GRAN_SH{1'b1}}} : EXT_W'(s.limit);
  assign off_ext = EXT_W'(off_i);
  assign over    = off_ext > eff_lim;
  assign lim_bad = s.dn ? !over : over;

  always_comb begin
    case (acc_kind_e'(kind_i))
      ACC_RD:  kind_bad = !s.rd;
      ACC_WR:  kind_bad = !s.wr;
      ACC_EX:  kind_bad = !s.ex;
      default: kind_bad = 1'b1;
    endcase
  end

  assign fault_c = !seg_ok || lim_bad || kind_bad;
  assign lin     = s.base + off_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      addr_o  <= '0;
      fault_o <= 1'b0;
    end else begin
      valid_o <= accept_i;
      if (accept_i) begin
        fault_o <= fault_c;
        addr_o  <= fault_c ? '0 : lin;
      end
    end
  end

endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
  import segx_pkg::*;
#(
  parameter int NSEG  = 6,
  parameter int SEL_W = 16,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int IDX_W = (NSEG > 1) ? $clog2(NSEG) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             legacy_mode,
  input  logic [AW-1:0]    dt_base,
  input  logic             sel_wr_en,
  input  logic [IDX_W-1:0] sel_wr_idx,
  input  logic [SEL_W-1:0] sel_wr_data,
  output logic             mem_rd_req,
  output logic [AW-1:0]    mem_rd_addr,
  input  logic             mem_rd_valid,
  input  logic [DW-1:0]    mem_rd_data,
  input  logic             xl_req,
  input  logic [IDX_W-1:0] xl_seg,
  input  logic [AW-1:0]    xl_off,
  input  logic [1:0]       xl_kind,
  output logic             xl_ready,
  output logic             xl_valid,
  output logic [AW-1:0]    xl_addr,
  output logic             xl_fault,
  output logic             busy
);

  logic [SEL_W-1:0] sel_q [NSEG];
  shadow_t          shd_q [NSEG];
  logic             wr_ok;
  logic             commit_en;
  logic [IDX_W-1:0] commit_idx;
  shadow_t          commit_data;
  logic [NSEG-1:0]  seg_busy;
  logic             xl_in_range;

  assign wr_ok       = sel_wr_en && (32'(sel_wr_idx) < NSEG);
  assign xl_in_range = (32'(xl_seg) < NSEG);
  assign xl_ready    = xl_in_range ? !seg_busy[xl_seg] : 1'b1;
  assign busy        = |seg_busy;

  seg_shadow_file #(
    .NSEG (NSEG),
    .IDX_W(IDX_W),
    .SEL_W(SEL_W)
  ) shadow_i (
    .clk          (clk),
    .rst          (rst),
    .legacy_i     (legacy_mode),
    .wr_en_i      (wr_ok),
    .wr_idx_i     (sel_wr_idx),
    .wr_sel_i     (sel_wr_data),
    .commit_en_i  (commit_en),
    .commit_idx_i (commit_idx),
    .commit_data_i(commit_data),
    .sel_o        (sel_q),
    .shd_o        (shd_q)
  );

  seg_fetch_engine #(
    .NSEG (NSEG),
    .IDX_W(IDX_W),
    .SEL_W(SEL_W),
    .AW   (AW),
    .DW   (DW)
  ) fetch_i (
    .clk           (clk),
    .rst           (rst),
    .legacy_i      (legacy_mode),
    .wr_en_i       (wr_ok),
    .wr_idx_i      (sel_wr_idx),
    .dt_base_i     (dt_base),
    .sel_i         (sel_q),
    .mem_rd_req_o  (mem_rd_req),
    .mem_rd_addr_o (mem_rd_addr),
    .mem_rd_valid_i(mem_rd_valid),
    .mem_rd_data_i (mem_rd_data),
    .commit_en_o   (commit_en),
    .commit_idx_o  (commit_idx),
    .commit_data_o (commit_data),
    .seg_busy_o    (seg_busy)
  );

  seg_limit_check #(
    .NSEG (NSEG),
    .IDX_W(IDX_W),
    .AW   (AW)
  ) check_i (
    .clk     (clk),
    .rst     (rst),
    .accept_i(xl_req && xl_ready),
    .seg_i   (xl_seg),
    .off_i   (xl_off),
    .kind_i  (xl_kind),
    .shd_i   (shd_q),
    .valid_o (xl_valid),
    .addr_o  (xl_addr),
    .fault_o (xl_fault)
  );

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int NSEG  = 6,
  parameter int IDX_W = 3,
  parameter int AW    = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             legacy_mode,
  input logic             sel_wr_en,
  input logic [IDX_W-1:0] sel_wr_idx,
  input logic             mem_rd_req,
  input logic             busy,
  input logic             xl_req,
  input logic [IDX_W-1:0] xl_seg,
  input logic             xl_ready,
  input logic             xl_valid,
  input logic [AW-1:0]    xl_addr,
  input logic             xl_fault
);

  AST_RESULT_FOLLOWS_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    xl_valid |-> $past(xl_req && xl_ready)); // R5

  AST_ACCEPT_GIVES_RESULT: assert property (@(posedge clk) disable iff (rst)
    (xl_req && xl_ready) |=> xl_valid); // R5

  AST_FAULT_ADDR_ZERO: assert property (@(posedge clk) disable iff (rst)
    (xl_valid && xl_fault) |-> (xl_addr == '0)); // R6

  AST_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    mem_rd_req |=> !mem_rd_req); // R2

  AST_LOAD_RAISES_BUSY: assert property (@(posedge clk) disable iff (rst)
    (sel_wr_en && !legacy_mode && 32'(sel_wr_idx) < NSEG) |=> busy); // R11

  AST_IDLE_MEANS_READY: assert property (@(posedge clk) disable iff (rst)
    !busy |-> xl_ready); // R11

  AST_LEGACY_NO_READ: assert property (@(posedge clk) disable iff (rst)
    legacy_mode |=> !mem_rd_req); // R10

  AST_BAD_SEG_FAULTS: assert property (@(posedge clk) disable iff (rst)
    (xl_req && xl_ready && 32'(xl_seg) >= NSEG) |=> (xl_valid && xl_fault)); // R13

  AST_BAD_SEG_READY: assert property (@(posedge clk) disable iff (rst)
    (32'(xl_seg) >= NSEG) |-> xl_ready); // R13

endmodule

bind seg_xlate_unit seg_xlate_chk #(
  .NSEG (NSEG),
  .IDX_W(IDX_W),
  .AW   (AW)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .legacy_mode(legacy_mode),
  .sel_wr_en  (sel_wr_en),
  .sel_wr_idx (sel_wr_idx),
  .mem_rd_req (mem_rd_req),
  .busy       (busy),
  .xl_req     (xl_req),
  .xl_seg     (xl_seg),
  .xl_ready   (xl_ready),
  .xl_valid   (xl_valid),
  .xl_addr    (xl_addr),
  .xl_fault   (xl_fault)
);

// File: tb/seg_xlate_unit_tb_top.sv
module seg_xlate_unit_tb_top;

  localparam logic [31:0] DT = 32'h0000_1000;
  localparam logic [31:0] F_RD = 32'h0100_0000;
  localparam logic [31:0] F_WR = 32'h0200_0000;
  localparam logic [31:0] F_EX = 32'h0400_0000;
  localparam logic [31:0] F_DN = 32'h0800_0000;
  localparam logic [31:0] F_GR = 32'h1000_0000;

  logic        clk = 1'b0;
  logic        rst;
  logic        legacy_mode;
  logic [31:0] dt_base;
  logic        sel_wr_en;
  logic [2:0]  sel_wr_idx;
  logic [15:0] sel_wr_data;
  logic        mem_rd_req;
  logic [31:0] mem_rd_addr;
  logic        mem_rd_valid;
  logic [31:0] mem_rd_data;
  logic        xl_req;
  logic [2:0]  xl_seg;
  logic [31:0] xl_off;
  logic [1:0]  xl_kind;
  logic        xl_ready;
  logic        xl_valid;
  logic [31:0] xl_addr;
  logic        xl_fault;
  logic        busy;

  always #5 clk = ~clk;

  seg_xlate_unit dut_i (
    .clk(clk), .rst(rst), .legacy_mode(legacy_mode), .dt_base(dt_base),
    .sel_wr_en(sel_wr_en), .sel_wr_idx(sel_wr_idx), .sel_wr_data(sel_wr_data),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .xl_req(xl_req), .xl_seg(xl_seg), .xl_off(xl_off), .xl_kind(xl_kind),
    .xl_ready(xl_ready), .xl_valid(xl_valid), .xl_addr(xl_addr),
    .xl_fault(xl_fault), .busy(busy)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  task automatic check(input logic ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // ---------------- memory model: answers two cycles after a request
  logic [31:0] mem_w [64];
  logic [31:0] rd_log [$];
  int          lat_cnt = 0;
  logic [5:0]  lat_idx = '0;

  always @(posedge clk) begin
    mem_rd_valid <= 1'b0;
    if (lat_cnt != 0) begin
      lat_cnt <= lat_cnt - 1;
      if (lat_cnt == 1) begin
        mem_rd_valid <= 1'b1;
        mem_rd_data  <= mem_w[lat_idx];
      end
    end
    if (!rst && mem_rd_req) begin
      lat_cnt <= 2;
      lat_idx <= 6'((mem_rd_addr - DT) >> 2);
      rd_log.push_back(mem_rd_addr);
    end
  end

  task automatic set_desc(input int idx, input logic [31:0] base, input logic [31:0] hi);
    mem_w[2*idx]     = base;
    mem_w[2*idx + 1] = hi;
  endtask

  // ---------------- scoreboard
  typedef struct {
    logic [31:0] addr;
    logic        fault;
    string       tag;
  } exp_t;

  exp_t exp_q [$];
  exp_t cur_e;

  always @(negedge clk) begin
    if (!rst && xl_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R5 unexpected result", {31'd0, xl_fault, xl_addr}, 64'd0);
      end else begin
        cur_e = exp_q.pop_front();
        check(xl_addr == cur_e.addr && xl_fault == cur_e.fault, cur_e.tag,
              {31'd0, xl_fault, xl_addr}, {31'd0, cur_e.fault, cur_e.addr});
      end
    end
  end

  task automatic xlate(input logic [2:0] seg, input logic [31:0] off, input logic [1:0] kind,
                       input logic [31:0] e_addr, input logic e_fault, input string tag);
    exp_t e;
    e.addr  = e_fault ? 32'd0 : e_addr;
    e.fault = e_fault;
    e.tag   = tag;
    exp_q.push_back(e);
    @(negedge clk);
    xl_req  = 1'b1;
    xl_seg  = seg;
    xl_off  = off;
    xl_kind = kind;
    #1;
    while (!xl_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    xl_req = 1'b0;
  endtask

  task automatic load_sel(input logic [2:0] seg, input logic [15:0] sel);
    @(negedge clk);
    sel_wr_en   = 1'b1;
    sel_wr_idx  = seg;
    sel_wr_data = sel;
    @(negedge clk);
    sel_wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    @(negedge clk);
    while (busy && n < 100) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic drain();
    int n = 0;
    while (exp_q.size() != 0 && n < 50) begin
      @(negedge clk);
      n++;
    end
  endtask

  // ---------------- watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements): actual 0x1 expected 0x0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus
  initial begin
    int rd0;
    rst = 1'b1;
    legacy_mode = 1'b0;
    dt_base = DT;
    sel_wr_en = 1'b0;
    sel_wr_idx = '0;
    sel_wr_data = '0;
    xl_req = 1'b0;
    xl_seg = '0;
    xl_off = '0;
    xl_kind = '0;
    mem_rd_valid = 1'b0;
    mem_rd_data = '0;
    for (int i = 0; i < 64; i++) mem_w[i] = 32'hDEAD_0000 + 32'(i);
    set_desc(3, 32'h0000_0100, F_RD | 32'h00FF_FFFF);
    set_desc(5, 32'h0004_0000, F_RD | F_WR | 32'h0000_0FFF);
    set_desc(6, 32'h8000_0000, F_RD | F_WR | F_DN | 32'h0000_00FF);
    set_desc(7, 32'h0000_0010, F_RD | F_EX | F_GR | 32'h0000_0001);

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    check(!busy && !mem_rd_req && !xl_valid, "R1 reset outputs",
          {61'd0, busy, mem_rd_req, xl_valid}, 64'd0);
    xlate(3'd0, 32'h0, 2'd0, 32'h0, 1'b1, "R1 empty shadow faults");
    drain();

    // R2/R11: descriptor load for segment 1, selector index 5, privilege 3
    load_sel(3'd1, 16'h0017);
    check(busy == 1'b1, "R11 busy after load", {63'd0, busy}, 64'd1);
    xl_seg = 3'd1;
    #1;
    check(xl_ready == 1'b0, "R11 loading segment not ready", {63'd0, xl_ready}, 64'd0);
    xl_seg = 3'd0;
    #1;
    check(xl_ready == 1'b1, "R11 other segment ready", {63'd0, xl_ready}, 64'd1);
    wait_idle();
    check(rd_log.size() == 2, "R2 two reads", 64'(rd_log.size()), 64'd2);
    if (rd_log.size() == 2) begin
      check(rd_log[0] == DT + 32'd40, "R2 first word address", 64'(rd_log[0]), 64'(DT + 32'd40));
      check(rd_log[1] == DT + 32'd44, "R2 second word address", 64'(rd_log[1]), 64'(DT + 32'd44));
    end

    // R4/R5/R6/R7 on segment 1
    xlate(3'd1, 32'h10, 2'd0, 32'h0004_0010, 1'b0, "R4 R5 read in range");
    xlate(3'd1, 32'hFFF, 2'd1, 32'h0004_0FFF, 1'b0, "R7 write at limit");
    xlate(3'd1, 32'h1000, 2'd0, 32'h0, 1'b1, "R7 past limit");
    xlate(3'd1, 32'h10, 2'd2, 32'h0, 1'b1, "R6 execute not allowed");
    xlate(3'd1, 32'h10, 2'd3, 32'h0, 1'b1, "R6 reserved kind");
    drain();

    // R3: same selector again refetches
    rd0 = rd_log.size();
    load_sel(3'd1, 16'h0017);
    wait_idle();
    check(rd_log.size() == rd0 + 2, "R3 reload fetches again",
          64'(rd_log.size()), 64'(rd0 + 2));

    // R8: expand-down in segment 2
    load_sel(3'd2, 16'h0018);
    wait_idle();
    xlate(3'd2, 32'hFF, 2'd0, 32'h0, 1'b1, "R8 at limit faults");
    xlate(3'd2, 32'h100, 2'd1, 32'h8000_0100, 1'b0, "R8 above limit ok");
    xlate(3'd2, 32'hFFFF_FFFF, 2'd0, 32'h7FFF_FFFF, 1'b0, "R8 R5 top offset wraps");

    // R9: granularity in segment 3
    load_sel(3'd3, 16'h001C);
    wait_idle();
    xlate(3'd3, 32'h1FFF, 2'd2, 32'h0000_200F, 1'b0, "R9 scaled limit edge");
    xlate(3'd3, 32'h2000, 2'd2, 32'h0, 1'b1, "R9 beyond scaled limit");
    xlate(3'd3, 32'h0, 2'd1, 32'h0, 1'b1, "R6 write not allowed");

    // R12: rewrite while fetching, last selector wins
    @(negedge clk);
    sel_wr_en = 1'b1;
    sel_wr_idx = 3'd4;
    sel_wr_data = 16'h0014;
    @(negedge clk);
    sel_wr_data = 16'h0018;
    @(negedge clk);
    sel_wr_en = 1'b0;
    wait_idle();
    xlate(3'd4, 32'h100, 2'd0, 32'h8000_0100, 1'b0, "R12 newer descriptor used");
    xlate(3'd4, 32'h10, 2'd0, 32'h0, 1'b1, "R12 older descriptor discarded");

    // R11: other segments keep translating during a load
    load_sel(3'd0, 16'h000C);
    xlate(3'd1, 32'h20, 2'd0, 32'h0004_0020, 1'b0, "R11 other segment during load");
    wait_idle();
    xlate(3'd0, 32'h5, 2'd0, 32'h0000_0105, 1'b0, "R11 loaded segment after busy");
    drain();

    // R13: nonexistent segments
    xlate(3'd6, 32'h0, 2'd0, 32'h0, 1'b1, "R13 segment 6 faults");
    rd0 = rd_log.size();
    load_sel(3'd7, 16'h0014);
    check(busy == 1'b0, "R13 write to segment 7 ignored", {63'd0, busy}, 64'd0);
    repeat (6) @(negedge clk);
    check(rd_log.size() == rd0, "R13 no fetch for segment 7", 64'(rd_log.size()), 64'(rd0));

    // R10: legacy mode
    legacy_mode = 1'b1;
    rd0 = rd_log.size();
    load_sel(3'd5, 16'h1234);
    check(busy == 1'b0, "R10 no busy in legacy", {63'd0, busy}, 64'd0);
    xlate(3'd5, 32'hFFFF, 2'd1, 32'h0002_233F, 1'b0, "R10 legacy base and limit");
    xlate(3'd5, 32'h1_0000, 2'd0, 32'h0, 1'b1, "R10 legacy past 64 KiB");
    xlate(3'd5, 32'h0, 2'd2, 32'h0001_2340, 1'b0, "R10 legacy execute allowed");
    drain();
    repeat (4) @(negedge clk);
    check(rd_log.size() == rd0, "R10 no memory read", 64'(rd_log.size()), 64'(rd0));
    check(exp_q.size() == 0, "R5 all results returned", 64'(exp_q.size()), 64'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule